// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Block

This block is the register set a host uses to control one bus-master disk DMA channel. It holds three things: a command register, a status register and a 32-bit pointer to the descriptor table. The command register carries a start bit and a transfer direction bit. The status register reports whether the channel is active, whether an error occurred and whether the drive has interrupted. The pointer register can be read and written one, two or four bytes at a time at any byte offset.

The block watches the start bit for changes. When the start bit changes from 0 to 1, it copies the stored pointer into a current-pointer output. If the channel is idle, it also marks the channel active and sends a one-cycle start pulse to the descriptor walker, which is a separate block.

When the start bit changes from 1 to 0, a transfer that is already running is not cut off. The channel stays active until the walker reports that it is done. The drive interrupt line passes straight through to the host, and each rising edge of it is recorded in the status register.

Top module: `bmdma_regs`

## Requirements
- R1: A command write (select code 0) keeps only bit 0 (start) and bit 3 (direction). A command read returns those two bits in their positions, with every other bit zero. `dir_o` follows the stored bit 3.
- R2: A command write that leaves the start bit at its stored value changes neither the active state nor `cur_ptr_o`, and it produces no start pulse.
- R3: When a command write changes the start bit from 0 to 1, `cur_ptr_o` is loaded from the pointer register. If the channel was inactive, it becomes active and `start_pulse_o` is high for exactly the one cycle after the write. If the channel was still active, no pulse is produced.
- R4: When a command write changes the start bit from 1 to 0 while `xfer_busy_i` is high, the channel stays active. When `xfer_busy_i` is low at that write, the channel goes inactive in the cycle after the write.
- R5: A pointer write (select code 2) with size code 0 writes 1 byte, size code 1 writes 2 bytes, and size code 2 or 3 writes 4 bytes. The data sits low-aligned in `acc_wdata`, and only the byte lanes from `acc_off` upward, within the pointer, are replaced. Bits [1:0] of the stored pointer are always zero.
- R6: A pointer read returns the stored value shifted right by 8 × `acc_off`, with only the number of bytes given by the size code kept.
- R7: `host_irq_o` equals `drv_irq_i` at all times. A rising edge on `drv_irq_i` sets the interrupt status bit (status bit 2) one cycle later.
- R8: Status (select code 1) reads back bit 0 = active, bit 1 = error and bit 2 = interrupt. Writing 1 to bit 1 or bit 2 clears that bit, and bit 0 cannot be written. `xfer_err_i` sets the error bit.
- R9: A `xfer_done_i` pulse makes an active channel inactive in the next cycle.
- R10: Reset clears the command, status, pointer and current-pointer registers and holds the start pulse low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Register access strobe |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 2 | 0 command, 1 status, 2 pointer |
| acc_off | input | 2 | Byte offset within the pointer register |
| acc_size | input | 2 | Access size code (0: 1 byte, 1: 2 bytes, 2 or 3: 4 bytes) |
| acc_wdata | input | 32 | Write data, low-aligned |
| acc_rdata | output | 32 | Read data for the current select, offset and size |
| drv_irq_i | input | 1 | Drive interrupt level |
| host_irq_o | output | 1 | Interrupt level forwarded to the host |
| xfer_busy_i | input | 1 | Walker has a transfer in flight |
| xfer_done_i | input | 1 | Walker completion pulse |
| xfer_err_i | input | 1 | Walker error pulse |
| start_pulse_o | output | 1 | One-cycle start request to the walker |
| cur_ptr_o | output | 32 | Current descriptor table pointer |
| dir_o | output | 1 | Transfer direction from command bit 3 |

## Verification
The hardest state to reach from the ports is a channel that has been told to stop but is still active because the walker is busy, followed by a second 0-to-1 start write. That second write must reload the current pointer without issuing a new pulse. The bench gets there by driving the walker-busy input itself: it holds the input high across a stop write, rewrites the pointer, and then starts the channel again. It only releases the channel with a completion pulse after it has checked the reload and the absence of a pulse. Byte-lane writes that spill past the top lane are also covered, with a two-byte write at offset 3.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_STAT = 2'd1,
        SEL_PTR  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int CMD_START_BIT = 0;
    localparam int CMD_DIR_BIT   = 3;
    localparam int ST_ACT_BIT    = 0;
    localparam int ST_ERR_BIT    = 1;
    localparam int ST_INT_BIT    = 2;
endpackage

// File: rtl/bmdma_lane_mux.sv
module bmdma_lane_mux #(
    parameter int NB = 4,
    localparam int OW = (NB > 1) ? $clog2(NB) : 1,
    localparam int DW = NB * 8
) (
    input  logic [OW-1:0] off_i,
    input  logic [1:0]    size_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] cur_i,
    output logic [DW-1:0] merged_o,
    output logic [DW-1:0] rdata_o
);
    int nbytes;
    logic [DW-1:0] wr_shift;
    logic [DW-1:0] rd_shift;

    always_comb begin
        case (size_i)
            2'd0:    nbytes = 1;
            2'd1:    nbytes = 2;
            default: nbytes = 4;
        endcase
        wr_shift = wdata_i << {off_i, 3'b000};
        rd_shift = cur_i >> {off_i, 3'b000};
    end

    for (genvar i = 0; i < NB; i++) begin : g_lane
        logic lane_wr;
        always_comb begin
            lane_wr = (int'(off_i) <= i) && (i < int'(off_i) + nbytes);
        end
        assign merged_o[8*i +: 8] = lane_wr ? wr_shift[8*i +: 8] : cur_i[8*i +: 8];
        assign rdata_o[8*i +: 8]  = (i < nbytes) ? rd_shift[8*i +: 8] : 8'h00;
    end
endmodule

// File: rtl/bmdma_xfer_ctl.sv
module bmdma_xfer_ctl #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr_i,
    input  logic          start_wr_i,
    input  logic [AW-1:0] ptr_i,
    input  logic          xfer_busy_i,
    input  logic          xfer_done_i,
    output logic          start_o,
    output logic          active_o,
    output logic          pulse_o,
    output logic [AW-1:0] cur_ptr_o
);
    typedef struct packed {
        logic          start;
        logic          active;
        logic          pulse;
        logic [AW-1:0] cur_ptr;
    } ctl_st_t;

    ctl_st_t ctl_d, ctl_q;
    logic rise, fall;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.pulse = 1'b0;
        rise = cmd_wr_i && start_wr_i && !ctl_q.start;
        fall = cmd_wr_i && !start_wr_i && ctl_q.start;
        if (xfer_done_i) begin
            ctl_d.active = 1'b0;
        end
        if (fall && !xfer_busy_i) begin
            ctl_d.active = 1'b0;
        end
        if (rise) begin
            ctl_d.cur_ptr = ptr_i;
            if (!ctl_q.active) begin
                ctl_d.active = 1'b1;
                ctl_d.pulse  = 1'b1;
            end
        end
        if (cmd_wr_i) begin
            ctl_d.start = start_wr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign start_o   = ctl_q.start;
    assign active_o  = ctl_q.active;
    assign pulse_o   = ctl_q.pulse;
    assign cur_ptr_o = ctl_q.cur_ptr;
endmodule

// File: rtl/bmdma_irq_track.sv
module bmdma_irq_track (
    input  logic clk,
    input  logic rst_n,
    input  logic drv_irq_i,
    input  logic err_set_i,
    input  logic clr_wr_i,
    input  logic clr_int_i,
    input  logic clr_err_i,
    output logic int_o,
    output logic err_o
);
    typedef struct packed {
        logic irq_prev;
        logic int_st;
        logic err_st;
    } irq_st_t;

    irq_st_t irq_d, irq_q;

    always_comb begin
        irq_d          = irq_q;
        irq_d.irq_prev = drv_irq_i;
        if (clr_wr_i && clr_int_i) begin
            irq_d.int_st = 1'b0;
        end
        if (clr_wr_i && clr_err_i) begin
            irq_d.err_st = 1'b0;
        end
        if (drv_irq_i && !irq_q.irq_prev) begin
            irq_d.int_st = 1'b1;
        end
        if (err_set_i) begin
            irq_d.err_st = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign int_o = irq_q.int_st;
    assign err_o = irq_q.err_st;
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
    import bmdma_pkg::*;
#(
    parameter int AW = 32,
    localparam int NB = AW / 8,
    localparam int OW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_en,
    input  logic          acc_we,
    input  logic [1:0]    acc_sel,
    input  logic [OW-1:0] acc_off,
    input  logic [1:0]    acc_size,
    input  logic [AW-1:0] acc_wdata,
    output logic [AW-1:0] acc_rdata,
    input  logic          drv_irq_i,
    output logic          host_irq_o,
    input  logic          xfer_busy_i,
    input  logic          xfer_done_i,
    input  logic          xfer_err_i,
    output logic          start_pulse_o,
    output logic [AW-1:0] cur_ptr_o,
    output logic          dir_o
);
    typedef struct packed {
        logic          dir;
        logic [AW-1:0] ptr;
    } top_st_t;

    top_st_t  top_d, top_q;
    reg_sel_e sel;
    logic     cmd_wr, stat_wr, ptr_wr;
    logic     start_w, active_w, int_w, err_w;
    logic [AW-1:0] merged_w, lane_rd_w;

    always_comb begin
        sel     = reg_sel_e'(acc_sel);
        cmd_wr  = acc_en && acc_we && (sel == SEL_CMD);
        stat_wr = acc_en && acc_we && (sel == SEL_STAT);
        ptr_wr  = acc_en && acc_we && (sel == SEL_PTR);
    end

    bmdma_lane_mux #(.NB(NB)) u_lane (
        .off_i   (acc_off),
        .size_i  (acc_size),
        .wdata_i (acc_wdata),
        .cur_i   (top_q.ptr),
        .merged_o(merged_w),
        .rdata_o (lane_rd_w)
    );

    bmdma_xfer_ctl #(.AW(AW)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr_i   (cmd_wr),
        .start_wr_i (acc_wdata[CMD_START_BIT]),
        .ptr_i      (top_q.ptr),
        .xfer_busy_i(xfer_busy_i),
        .xfer_done_i(xfer_done_i),
        .start_o    (start_w),
        .active_o   (active_w),
        .pulse_o    (start_pulse_o),
        .cur_ptr_o  (cur_ptr_o)
    );

    bmdma_irq_track u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .drv_irq_i(drv_irq_i),
        .err_set_i(xfer_err_i),
        .clr_wr_i (stat_wr),
        .clr_int_i(acc_wdata[ST_INT_BIT]),
        .clr_err_i(acc_wdata[ST_ERR_BIT]),
        .int_o    (int_w),
        .err_o    (err_w)
    );

    always_comb begin
        top_d = top_q;
        if (cmd_wr) begin
            top_d.dir = acc_wdata[CMD_DIR_BIT];
        end
        if (ptr_wr) begin
            top_d.ptr = {merged_w[AW-1:2], 2'b00};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    always_comb begin
        acc_rdata = '0;
        case (sel)
            SEL_CMD: begin
                acc_rdata[CMD_START_BIT] = start_w;
                acc_rdata[CMD_DIR_BIT]   = top_q.dir;
            end
            SEL_STAT: begin
                acc_rdata[ST_ACT_BIT] = active_w;
                acc_rdata[ST_ERR_BIT] = err_w;
                acc_rdata[ST_INT_BIT] = int_w;
            end
            SEL_PTR:  acc_rdata = lane_rd_w;
            default:  acc_rdata = '0;
        endcase
    end

    assign host_irq_o = drv_irq_i;
    assign dir_o      = top_q.dir;
endmodule

// File: rtl/bmdma_regs_chk.sv
module bmdma_regs_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          acc_en,
    input logic          acc_we,
    input logic [1:0]    acc_sel,
    input logic [AW-1:0] acc_rdata,
    input logic          drv_irq_i,
    input logic          xfer_done_i,
    input logic          start_pulse_o,
    input logic [AW-1:0] cur_ptr_o,
    input logic          active_w,
    input logic          int_w
);
    p_cmd_rsvd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_we && acc_sel == 2'd0) |->
            (acc_rdata[AW-1:4] == '0 && acc_rdata[2:1] == 2'b00));

    p_pulse_fresh_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse_o |-> !$past(active_w));

    p_pulse_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse_o |=> !start_pulse_o);

    p_pulse_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse_o |-> active_w);

    p_cur_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cur_ptr_o[1:0] == 2'b00);

    p_irq_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_irq_i) |=> int_w);

    p_done_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done_i && active_w) |=> !active_w);
endmodule

bind bmdma_regs bmdma_regs_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_en       (acc_en),
    .acc_we       (acc_we),
    .acc_sel      (acc_sel),
    .acc_rdata    (acc_rdata),
    .drv_irq_i    (drv_irq_i),
    .xfer_done_i  (xfer_done_i),
    .start_pulse_o(start_pulse_o),
    .cur_ptr_o    (cur_ptr_o),
    .active_w     (active_w),
    .int_w        (int_w)
);

// File: tb/bmdma_regs_tb_top.sv
module bmdma_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_we = 1'b0;
    logic [1:0]  acc_sel = 2'd3;
    logic [1:0]  acc_off = 2'd0;
    logic [1:0]  acc_size = 2'd2;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        drv_irq = 1'b0;
    logic        host_irq;
    logic        busy = 1'b0;
    logic        done = 1'b0;
    logic        err = 1'b0;
    logic        start_pulse;
    logic [31:0] cur_ptr;
    logic        dir;

    int n_chk = 0;
    int n_fail = 0;
    logic last_pulse;
    logic [31:0] rv;

    always #2 clk = ~clk;

    bmdma_regs dut_i (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
        .acc_sel(acc_sel), .acc_off(acc_off), .acc_size(acc_size),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .drv_irq_i(drv_irq), .host_irq_o(host_irq),
        .xfer_busy_i(busy), .xfer_done_i(done), .xfer_err_i(err),
        .start_pulse_o(start_pulse), .cur_ptr_o(cur_ptr), .dir_o(dir)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [1:0] o, input logic [1:0] z,
                      input logic [31:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b1; acc_sel = s; acc_off = o; acc_size = z; acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
        last_pulse = start_pulse;
    endtask

    task automatic rd(input logic [1:0] s, input logic [1:0] o, input logic [1:0] z,
                      output logic [31:0] v);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b0; acc_sel = s; acc_off = o; acc_size = z;
        #1 v = acc_rdata;
        acc_en = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); done = 1'b1;
        @(negedge clk); done = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 pulse low in reset", {31'b0, start_pulse}, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        rd(2'd0, 2'd0, 2'd0, rv); check("R10 cmd after reset", rv, 32'h0);
        rd(2'd1, 2'd0, 2'd0, rv); check("R10 status after reset", rv, 32'h0);
        rd(2'd2, 2'd0, 2'd2, rv); check("R10 ptr after reset", rv, 32'h0);
        check("R10 cur_ptr after reset", cur_ptr, 32'h0);
    endtask

    task automatic t_cmd_bits();
        wr(2'd0, 2'd0, 2'd0, 32'h0000_00FE);
        rd(2'd0, 2'd0, 2'd0, rv); check("R1 cmd keeps bit3 only", rv, 32'h08);
        check("R1 dir output", {31'b0, dir}, 32'h1);
        check("R2 no pulse when start stays 0", {31'b0, last_pulse}, 32'h0);
        wr(2'd0, 2'd0, 2'd0, 32'h0000_00F6);
        rd(2'd0, 2'd0, 2'd0, rv); check("R1 cmd clears", rv, 32'h00);
    endtask

    task automatic t_ptr();
        wr(2'd2, 2'd0, 2'd2, 32'h1234_5677);
        rd(2'd2, 2'd0, 2'd2, rv); check("R5 full write aligned", rv, 32'h1234_5674);
        wr(2'd2, 2'd2, 2'd0, 32'h0000_00AB);
        rd(2'd2, 2'd0, 2'd2, rv); check("R5 byte at off2", rv, 32'h12AB_5674);
        wr(2'd2, 2'd1, 2'd1, 32'h0000_CDEF);
        rd(2'd2, 2'd0, 2'd2, rv); check("R5 half at off1", rv, 32'h12CD_EF74);
        wr(2'd2, 2'd0, 2'd0, 32'h0000_00FF);
        rd(2'd2, 2'd0, 2'd2, rv); check("R5 byte at off0 low bits forced", rv, 32'h12CD_EFFC);
        rd(2'd2, 2'd2, 2'd1, rv); check("R6 half read off2", rv, 32'h0000_12CD);
        rd(2'd2, 2'd1, 2'd0, rv); check("R6 byte read off1", rv, 32'h0000_00EF);
        wr(2'd2, 2'd3, 2'd1, 32'h0000_BEEF);
        rd(2'd2, 2'd0, 2'd3, rv); check("R5 half at off3 top lane only", rv, 32'hEFCD_EFFC);
        rd(2'd2, 2'd3, 2'd0, rv); check("R6 byte read off3", rv, 32'h0000_00EF);
    endtask

    task automatic t_start();
        wr(2'd2, 2'd0, 2'd2, 32'h0000_1000);
        wr(2'd0, 2'd0, 2'd0, 32'h0000_0001);
        check("R3 start pulse", {31'b0, last_pulse}, 32'h1);
        check("R3 cur_ptr loaded", cur_ptr, 32'h0000_1000);
        rd(2'd1, 2'd0, 2'd0, rv); check("R3 active set", rv, 32'h01);
        check("R3 pulse one cycle", {31'b0, start_pulse}, 32'h0);
    endtask

    task automatic t_nochange();
        wr(2'd2, 2'd0, 2'd2, 32'h0000_2000);
        wr(2'd0, 2'd0, 2'd0, 32'h0000_0001);
        check("R2 no pulse on same start", {31'b0, last_pulse}, 32'h0);
        check("R2 cur_ptr kept", cur_ptr, 32'h0000_1000);
        wr(2'd0, 2'd0, 2'd0, 32'h0000_0009);
        check("R2 no pulse on dir change", {31'b0, last_pulse}, 32'h0);
        check("R1 dir set while running", {31'b0, dir}, 32'h1);
        rd(2'd1, 2'd0, 2'd0, rv); check("R2 still active", rv, 32'h01);
    endtask

    task automatic t_stop_busy();
        busy = 1'b1;
        wr(2'd0, 2'd0, 2'd0, 32'h0000_0000);
        rd(2'd1, 2'd0, 2'd0, rv); check("R4 active held while busy", rv, 32'h01);
        repeat (3) @(negedge clk);
        rd(2'd1, 2'd0, 2'd0, rv); check("R4 active still held", rv, 32'h01);
        pulse_done();
        busy = 1'b0;
        rd(2'd1, 2'd0, 2'd0, rv); check("R9 done clears active", rv, 32'h00);
    endtask

    task automatic t_stop_idle();
        wr(2'd0, 2'd0, 2'd0, 32'h0000_0001);
        check("R3 restart pulse", {31'b0, last_pulse}, 32'h1);
        check("R3 cur_ptr reloaded", cur_ptr, 32'h0000_2000);
        wr(2'd0, 2'd0, 2'd0, 32'h0000_0000);
        rd(2'd1, 2'd0, 2'd0, rv); check("R4 idle stop clears active", rv, 32'h00);
    endtask

    task automatic t_done();
        wr(2'd0, 2'd0, 2'd0, 32'h0000_0001);
        pulse_done();
        rd(2'd1, 2'd0, 2'd0, rv); check("R9 done with start still set", rv, 32'h00);
        rd(2'd0, 2'd0, 2'd0, rv); check("R1 start bit still reads 1", rv, 32'h01);
        wr(2'd0, 2'd0, 2'd0, 32'h0000_0000);
    endtask

    task automatic t_restart_active();
        wr(2'd0, 2'd0, 2'd0, 32'h0000_0001);
        busy = 1'b1;
        wr(2'd0, 2'd0, 2'd0, 32'h0000_0000);
        wr(2'd2, 2'd0, 2'd2, 32'h0000_3000);
        wr(2'd0, 2'd0, 2'd0, 32'h0000_0001);
        check("R3 no pulse when still active", {31'b0, last_pulse}, 32'h0);
        check("R3 cur_ptr reloaded while active", cur_ptr, 32'h0000_3000);
        rd(2'd1, 2'd0, 2'd0, rv); check("R3 active kept", rv, 32'h01);
        pulse_done();
        busy = 1'b0;
        wr(2'd0, 2'd0, 2'd0, 32'h0000_0000);
        rd(2'd1, 2'd0, 2'd0, rv); check("R9 channel idle again", rv, 32'h00);
    endtask

    task automatic t_irq();
        @(negedge clk); drv_irq = 1'b1;
        #1 check("R7 host irq rises", {31'b0, host_irq}, 32'h1);
        rd(2'd1, 2'd0, 2'd0, rv); check("R7 int bit set", rv, 32'h04);
        @(negedge clk); drv_irq = 1'b0;
        #1 check("R7 host irq falls", {31'b0, host_irq}, 32'h0);
        rd(2'd1, 2'd0, 2'd0, rv); check("R7 int bit held", rv, 32'h04);
        wr(2'd1, 2'd0, 2'd0, 32'h0000_0004);
        rd(2'd1, 2'd0, 2'd0, rv); check("R8 int cleared by W1C", rv, 32'h00);
        wr(2'd1, 2'd0, 2'd0, 32'h0000_0001);
        rd(2'd1, 2'd0, 2'd0, rv); check("R8 active not writable", rv, 32'h00);
        @(negedge clk); err = 1'b1;
        @(negedge clk); err = 1'b0;
        rd(2'd1, 2'd0, 2'd0, rv); check("R8 err bit set", rv, 32'h02);
        wr(2'd1, 2'd0, 2'd0, 32'h0000_0004);
        rd(2'd1, 2'd0, 2'd0, rv); check("R8 err kept on int clear", rv, 32'h02);
        wr(2'd1, 2'd0, 2'd0, 32'h0000_0002);
        rd(2'd1, 2'd0, 2'd0, rv); check("R8 err cleared", rv, 32'h00);
    endtask

    task automatic t_reset2();
        wr(2'd2, 2'd0, 2'd2, 32'h0000_4440);
        wr(2'd0, 2'd0, 2'd0, 32'h0000_0009);
        @(negedge clk); drv_irq = 1'b1;
        @(negedge clk); drv_irq = 1'b0;
        do_reset();
        t_reset();
        check("R10 dir cleared", {31'b0, dir}, 32'h0);
    endtask

    initial begin
        #(4 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 pulse low in reset", {31'b0, start_pulse}, 32'h0);
        rst_n = 1'b1;
        t_reset();
        t_cmd_bits();
        t_ptr();
        t_start();
        t_nochange();
        t_stop_busy();
        t_stop_idle();
        t_done();
        t_restart_active();
        t_irq();
        t_reset2();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule